// File: doc/BRIEF.md
# Field-Configurable AND-OR Logic Array

This block is a combinational sum-of-products array whose links are stored in flops and can be rewritten in the field. Eight dedicated inputs and ten pad channels supply eighteen variables. Each variable enters an AND plane in true and inverted form. The AND plane builds 32 logic terms and 10 direction terms. A fully shared OR plane combines the logic terms into ten sums. Each sum passes through a selectable inverter and appears on a pad channel, and that channel's direction term drives its output enable. Each pad value seen on `pad_in` is fed back as a variable. When a channel is not enabled, that value is whatever the outside world drives.

The link pattern is loaded through a one-bit synchronous serial port into a shadow chain, and it only takes effect when a commit is requested. A capture copies the working pattern back into the chain so it can be shifted out for readback. A sticky lock bit, cleared only by reset, blocks readback. After reset the working pattern is the unprogrammed state: every link is present.

The loader is a four-state machine:
- `ST_IDLE` moves to `ST_COMMIT` on `cfg_load`. Otherwise it moves to `ST_CAPTURE` on `cfg_capture` when not locked. Otherwise it moves to `ST_SHIFT` on `cfg_shift`, shifting one bit on the way.
- `ST_SHIFT` stays while `cfg_shift` is high. Otherwise it goes to `ST_COMMIT` on `cfg_load`, or else back to `ST_IDLE`.
- `ST_COMMIT` copies the chain into the working pattern and returns to `ST_IDLE`.
- `ST_CAPTURE` copies the working pattern into the chain and returns to `ST_IDLE`.

Top module: `pla_array`

## Requirements
- R1: After reset every link of the working pattern is 1, so all terms are dead, every `pad_oe` is 0 and every `pad_out` is 0; a capture followed by readback returns all ones.
- R2: Term t uses pattern bits starting at t*2*V, where V is the number of variables (dedicated inputs first, then pad channels). Bit 2v is the true link of variable v and bit 2v+1 is its inverted link. The term is the AND of the literals whose link is 1, and a term with no links is 1. Terms 0..NP-1 are logic terms and term NP+n is the direction term of channel n.
- R3: A term with both links of any one variable set to 1 is 0 for every input.
- R4: OR-plane bit at offset A + p*NC + n, where A is the AND-plane size and NC the channel count, connects logic term p to channel n. The channel sum is the OR of all connected terms, and any term may feed any number of channels, up to all NP terms on one channel.
- R5: Polarity bit n at offset A + NP*NC + n selects the output: 1 passes the sum unchanged and 0 inverts it.
- R6: `pad_oe[n]` equals direction term n, and the variable for channel n is `pad_in[n]`, which carries the external value while the channel is not enabled.
- R7: While `cfg_shift` is accepted, each clock moves the chain up one place with `cfg_data` entering bit 0. `cfg_dout` shows the chain's top bit. Shifting leaves the pad outputs unchanged.
- R8: A `cfg_load` sampled in `ST_IDLE` or in `ST_SHIFT` (with shift low) changes the outputs on the second rising edge after it, not the first.
- R9: `cfg_capture` sampled in `ST_IDLE` while unlocked copies the working pattern into the chain two edges later, so it can be read out most significant bit first.
- R10: `cfg_lock` sets a lock that holds until reset. While locked, `cfg_dout` is 0 and captures are ignored, but loading and commits still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, restores the unprogrammed pattern |
| cfg_shift | input | 1 | Shift one bit into the chain |
| cfg_data | input | 1 | Serial data into the chain |
| cfg_load | input | 1 | Request commit of the chain |
| cfg_capture | input | 1 | Request copy of the working pattern into the chain |
| cfg_lock | input | 1 | Set the sticky readback lock |
| cfg_dout | output | 1 | Serial readback, top bit of the chain |
| ded_in | input | N_IN | Dedicated input variables |
| pad_in | input | N_IO | Value present at each pad channel |
| pad_out | output | N_IO | Value each channel drives when enabled |
| pad_oe | output | N_IO | Output enable per channel |

## Verification
The bench builds the array with 4 dedicated inputs, 4 pad channels and 8 logic terms. This gives 8 variables and a 228-bit pattern. With these values every combination of inputs and external pad values (256 patterns) is swept under each programmed function. An OR of all logic terms lands on one channel. Full readback and reload of a pattern takes a few hundred cycles. The same term and variable counts at their defaults would put an exhaustive sweep of 18 variables out of reach.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT,
        ST_CAPTURE
    } cfg_state_e;

    function automatic int cfg_width(input int n_in, input int n_io, input int n_pt);
        int n_var;
        int n_term;
        n_var  = n_in + n_io;
        n_term = n_pt + n_io;
        return n_term * 2 * n_var + n_pt * n_io + n_io;
    endfunction

endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl #(
    parameter int CFG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift,
    input  logic             cfg_data,
    input  logic             cfg_load,
    input  logic             cfg_capture,
    input  logic             cfg_lock,
    output logic             cfg_dout,
    output logic [CFG_W-1:0] active_cfg
);

    pla_pkg::cfg_state_e state_q, state_d;
    logic [CFG_W-1:0]    shadow_q;
    logic [CFG_W-1:0]    active_q;
    logic                locked_q;
    logic                shift_en;

    // next-state and strobe logic
    always_comb begin
        state_d  = state_q;
        shift_en = 1'b0;
        unique case (state_q)
            pla_pkg::ST_IDLE: begin
                if (cfg_load) begin
                    state_d = pla_pkg::ST_COMMIT;
                end else if (cfg_capture && !locked_q && !cfg_lock) begin
                    state_d = pla_pkg::ST_CAPTURE;
                end else if (cfg_shift) begin
                    state_d  = pla_pkg::ST_SHIFT;
                    shift_en = 1'b1;
                end
            end
            pla_pkg::ST_SHIFT: begin
                if (cfg_shift) begin
                    shift_en = 1'b1;
                end else if (cfg_load) begin
                    state_d = pla_pkg::ST_COMMIT;
                end else begin
                    state_d = pla_pkg::ST_IDLE;
                end
            end
            pla_pkg::ST_COMMIT:  state_d = pla_pkg::ST_IDLE;
            pla_pkg::ST_CAPTURE: state_d = pla_pkg::ST_IDLE;
            default:             state_d = pla_pkg::ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= pla_pkg::ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pattern storage and lock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '1;
            locked_q <= 1'b0;
        end else begin
            if (cfg_lock) begin
                locked_q <= 1'b1;
            end
            if (shift_en) begin
                shadow_q <= {shadow_q[CFG_W-2:0], cfg_data};
            end
            if (state_q == pla_pkg::ST_CAPTURE) begin
                shadow_q <= active_q;
            end
            if (state_q == pla_pkg::ST_COMMIT) begin
                active_q <= shadow_q;
            end
        end
    end

    // outputs
    always_comb begin
        cfg_dout   = locked_q ? 1'b0 : shadow_q[CFG_W-1];
        active_cfg = active_q;
    end

    // R7 / R8: the working pattern moves only in the commit state
    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != pla_pkg::ST_COMMIT) |=> $stable(active_q));

    // R10: lock is sticky
    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);

    // R10: no capture ever runs while locked
    p_no_capture_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |-> (state_q != pla_pkg::ST_CAPTURE));

    // R7: an accepted shift puts the serial bit at the bottom of the chain
    p_shift_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == pla_pkg::ST_SHIFT && cfg_shift) |=> (shadow_q[0] == $past(cfg_data)));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_VAR  = 18,
    parameter int N_TERM = 42
) (
    input  logic [N_VAR-1:0]          vars,
    input  logic [N_TERM*2*N_VAR-1:0] and_cfg,
    output logic [N_TERM-1:0]         terms
);

    localparam int ROW_W = 2 * N_VAR;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_VAR-1:0] true_link;
        logic [N_VAR-1:0] comp_link;
        for (genvar v = 0; v < N_VAR; v++) begin : g_var
            assign true_link[v] = and_cfg[t*ROW_W + 2*v];
            assign comp_link[v] = and_cfg[t*ROW_W + 2*v + 1];
        end
        // a removed link reads as 1 and leaves the product alone
        assign terms[t] = &((~true_link | vars) & (~comp_link | ~vars));
    end

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
    parameter int N_PT = 32,
    parameter int N_IO = 10
) (
    input  logic [N_PT-1:0]      prod,
    input  logic [N_PT*N_IO-1:0] or_cfg,
    input  logic [N_IO-1:0]      pol_cfg,
    input  logic [N_IO-1:0]      dir_terms,
    output logic [N_IO-1:0]      pad_out,
    output logic [N_IO-1:0]      pad_oe
);

    for (genvar n = 0; n < N_IO; n++) begin : g_chan
        logic [N_PT-1:0] column;
        logic            sum;
        for (genvar p = 0; p < N_PT; p++) begin : g_col
            assign column[p] = or_cfg[p*N_IO + n];
        end
        assign sum        = |(prod & column);
        assign pad_out[n] = sum ^ ~pol_cfg[n];
        assign pad_oe[n]  = dir_terms[n];
    end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_IN = 8,
    parameter int N_IO = 10,
    parameter int N_PT = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_shift,
    input  logic            cfg_data,
    input  logic            cfg_load,
    input  logic            cfg_capture,
    input  logic            cfg_lock,
    output logic            cfg_dout,
    input  logic [N_IN-1:0] ded_in,
    input  logic [N_IO-1:0] pad_in,
    output logic [N_IO-1:0] pad_out,
    output logic [N_IO-1:0] pad_oe
);

    localparam int N_VAR  = N_IN + N_IO;
    localparam int N_TERM = N_PT + N_IO;
    localparam int AND_W  = N_TERM * 2 * N_VAR;
    localparam int OR_W   = N_PT * N_IO;
    localparam int CFG_W  = pla_pkg::cfg_width(N_IN, N_IO, N_PT);

    logic [CFG_W-1:0]  active_cfg;
    logic [N_VAR-1:0]  vars;
    logic [N_TERM-1:0] terms;

    assign vars = {pad_in, ded_in};

    pla_cfg_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_shift   (cfg_shift),
        .cfg_data    (cfg_data),
        .cfg_load    (cfg_load),
        .cfg_capture (cfg_capture),
        .cfg_lock    (cfg_lock),
        .cfg_dout    (cfg_dout),
        .active_cfg  (active_cfg)
    );

    pla_and_plane #(.N_VAR(N_VAR), .N_TERM(N_TERM)) u_and (
        .vars    (vars),
        .and_cfg (active_cfg[AND_W-1:0]),
        .terms   (terms)
    );

    pla_out_stage #(.N_PT(N_PT), .N_IO(N_IO)) u_out (
        .prod      (terms[N_PT-1:0]),
        .or_cfg    (active_cfg[AND_W +: OR_W]),
        .pol_cfg   (active_cfg[AND_W + OR_W +: N_IO]),
        .dir_terms (terms[N_TERM-1:N_PT]),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // per-term checks relating the stored links to the plane's result
    for (genvar t = 0; t < N_TERM; t++) begin : g_chk
        logic [N_VAR-1:0] tl;
        logic [N_VAR-1:0] cl;
        for (genvar v = 0; v < N_VAR; v++) begin : g_bit
            assign tl[v] = active_cfg[t*2*N_VAR + 2*v];
            assign cl[v] = active_cfg[t*2*N_VAR + 2*v + 1];
        end
        // R3: both links of one variable kill the term
        p_conflict_kills_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (|(tl & cl)) |-> !terms[t]);
        // R2: a term with every link removed is 1
        p_open_term_true_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (~|(tl | cl)) |-> terms[t]);
    end

endmodule

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;

    localparam int NIN = 4;
    localparam int NIO = 4;
    localparam int NPT = 8;
    localparam int NV  = NIN + NIO;
    localparam int NT  = NPT + NIO;
    localparam int OB  = NT * 2 * NV;
    localparam int PB  = OB + NPT * NIO;
    localparam int CB  = PB + NIO;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_shift = 1'b0, cfg_data = 1'b0, cfg_load = 1'b0;
    logic           cfg_capture = 1'b0, cfg_lock = 1'b0;
    logic           cfg_dout;
    logic [NIN-1:0] ded_in = '0;
    logic [NIO-1:0] ext = '0;
    logic [NIO-1:0] pad_in, pad_out, pad_oe;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [2*NIO-1:0] exp_q[$];
    string            tag_q[$];

    always #5 clk = ~clk;

    // pad model: an enabled channel shows its own drive
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    pla_array #(.N_IN(NIN), .N_IO(NIO), .N_PT(NPT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_data(cfg_data),
        .cfg_load(cfg_load), .cfg_capture(cfg_capture), .cfg_lock(cfg_lock),
        .cfg_dout(cfg_dout), .ded_in(ded_in), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [CB-1:0] act, input logic [CB-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // reference: returns {oe, out}, settling the pad feedback by iteration
    function automatic logic [2*NIO-1:0] model(input logic [CB-1:0] c,
                                               input logic [NIN-1:0] i,
                                               input logic [NIO-1:0] e);
        logic [NIO-1:0] pad, o, oe;
        logic [NT-1:0]  prod;
        pad = e; o = '0; oe = '0;
        for (int r = 0; r < 4; r++) begin
            logic [NV-1:0] x;
            x = {pad, i};
            for (int t = 0; t < NT; t++) begin
                prod[t] = 1'b1;
                for (int v = 0; v < NV; v++) begin
                    if (c[t*2*NV + 2*v] && !x[v]) prod[t] = 1'b0;
                    if (c[t*2*NV + 2*v + 1] && x[v]) prod[t] = 1'b0;
                end
            end
            for (int n = 0; n < NIO; n++) begin
                logic acc;
                acc = 1'b0;
                for (int p = 0; p < NPT; p++)
                    if (c[OB + p*NIO + n] && prod[p]) acc = 1'b1;
                o[n]   = c[PB + n] ? acc : ~acc;
                oe[n]  = prod[NPT + n];
                pad[n] = oe[n] ? o[n] : e[n];
            end
        end
        return {oe, o};
    endfunction

    function automatic logic [CB-1:0] lt(input logic [CB-1:0] c, input int t, input int v);
        c[t*2*NV + 2*v] = 1'b1; return c;
    endfunction
    function automatic logic [CB-1:0] lc(input logic [CB-1:0] c, input int t, input int v);
        c[t*2*NV + 2*v + 1] = 1'b1; return c;
    endfunction
    function automatic logic [CB-1:0] orl(input logic [CB-1:0] c, input int p, input int n);
        c[OB + p*NIO + n] = 1'b1; return c;
    endfunction

    // A: all-term OR on ch0, inverted odd-term OR on ch1, dead enable on ch2,
    //    enable of ch3 fed back from external ch2
    function automatic logic [CB-1:0] build_a();
        logic [CB-1:0] c;
        c = '0;
        for (int p = 0; p < NPT; p++) begin
            for (int b = 0; b < 3; b++)
                c = ((p >> b) & 1) ? lt(c, p, b) : lc(c, p, b);
            c = lt(c, p, 3);
            c = orl(c, p, 0);
            if (p % 2 == 1) c = orl(c, p, 1);
        end
        c[PB + 0] = 1'b1; c[PB + 2] = 1'b1; c[PB + 3] = 1'b1;
        c = lt(c, NPT + 1, 1);
        c = lt(c, NPT + 2, 0); c = lc(c, NPT + 2, 0);
        c = lt(c, NPT + 3, NIN + 2); c = lt(c, NPT + 3, 0);
        return c;
    endfunction

    // B: term0 from two fed-back pads, term1 shared by ch0 and ch3
    function automatic logic [CB-1:0] build_b();
        logic [CB-1:0] c;
        c = '0;
        c = lt(c, 0, NIN + 0); c = lt(c, 0, NIN + 1);
        c = lc(c, 1, 0); c = lt(c, 1, 1);
        c = orl(c, 0, 2); c = orl(c, 1, 3); c = orl(c, 1, 0);
        c[PB + 0] = 1'b1; c[PB + 1] = 1'b1; c[PB + 2] = 1'b1;
        for (int n = 0; n < NIO; n++) c = lt(c, NPT + n, 3);
        return c;
    endfunction

    task automatic shift_cfg(input logic [CB-1:0] c, output logic [CB-1:0] seen);
        for (int b = CB - 1; b >= 0; b--) begin
            @(negedge clk);
            seen[b]   = cfg_dout;
            cfg_shift = 1'b1;
            cfg_data  = c[b];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_data  = 1'b0;
    endtask

    task automatic do_load();
        @(negedge clk); cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_capture();
        @(negedge clk); cfg_capture = 1'b1;
        @(negedge clk); cfg_capture = 1'b0;
        @(negedge clk);
    endtask

    task automatic sweep(input logic [CB-1:0] c, input string tag);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            ded_in = k[NIN-1:0];
            ext    = k[NIN +: NIO];
            exp_q.push_back(model(c, k[NIN-1:0], k[NIN +: NIO]));
            tag_q.push_back(tag);
        end
        @(posedge clk); #3;
    endtask

    // monitor: compares each queued expectation after the next rising edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (exp_q.size() > 0) begin
                logic [2*NIO-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {pad_oe, pad_out}, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CB-1:0] cfg_a, cfg_b, seen;
        cfg_a = build_a();
        cfg_b = build_b();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: unprogrammed state at the pads
        @(negedge clk); ded_in = 4'h5; ext = 4'h3;
        @(posedge clk); #2; chk("R1 virgin pads", {pad_oe, pad_out}, '0);
        @(negedge clk); ded_in = 4'hA; ext = 4'hC;
        @(posedge clk); #2; chk("R1 virgin pads alt", {pad_oe, pad_out}, '0);

        // R1 / R9: readback of the unprogrammed pattern
        do_capture();
        shift_cfg(cfg_a, seen);
        chk("R1 R9 virgin readback", seen, '1);

        // R7: chain now holds A, outputs still unprogrammed
        @(negedge clk); ded_in = 4'hF; ext = 4'hF;
        @(posedge clk); #2; chk("R7 shift leaves pads", {pad_oe, pad_out}, '0);

        // R8: commit lands on the second edge
        @(negedge clk); ded_in = 4'h9; ext = 4'h4; cfg_load = 1'b1;
        @(posedge clk); #2; chk("R8 first edge old", {pad_oe, pad_out}, '0);
        @(negedge clk); cfg_load = 1'b0;
        @(posedge clk); #2; chk("R8 second edge new", {pad_oe, pad_out}, model(cfg_a, 4'h9, 4'h4));

        // R2 R3 R4 R5 R6: exhaustive sweep of A
        sweep(cfg_a, "R2 R3 R4 R5 R6 sweep A");

        // R6 R2: pattern B with pad feedback into terms
        shift_cfg(cfg_b, seen);
        do_load();
        sweep(cfg_b, "R2 R4 R6 sweep B");

        // R9: read B back while A goes in
        do_capture();
        shift_cfg(cfg_a, seen);
        chk("R9 readback B", seen, cfg_b);

        // R10: lock hides the chain (top bit of A is 1)
        @(negedge clk); cfg_lock = 1'b1;
        @(negedge clk); cfg_lock = 1'b0;
        chk("R10 dout locked", {{(CB-1){1'b0}}, cfg_dout}, '0);
        do_capture();
        chk("R10 dout after capture", {{(CB-1){1'b0}}, cfg_dout}, '0);
        @(negedge clk); ded_in = 4'h0; ext = 4'h0;
        do_load();
        @(posedge clk); #2;
        chk("R10 capture ignored, A committed", {pad_oe, pad_out}, model(cfg_a, 4'h0, 4'h0));
        chk("R10 lock survives commit", {{(CB-1){1'b0}}, cfg_dout}, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule